// File: doc/BRIEF.md
# Byte-Buffered 16-bit Timer/Event Counter

This block is a 16-bit up-counter that sits on an 8-bit register bus. It has three counting modes. In timer mode it counts ticks from a system-clock prescaler with eight selectable taps. In event mode it counts chosen edges on an external pin. In pulse-width mode it counts prescaler ticks only while the pin holds a chosen level. When the count passes all-ones it reloads from a 16-bit preload value, raises a one-cycle overflow request and toggles a frequency output. That output therefore runs at half the overflow rate.

Software moves the 16-bit value through a shared low-byte buffer, so both bytes are handled together. Writing the low byte only fills the buffer. Writing the high byte commits both bytes to the preload register at once. Reading the high byte returns the counter's upper half and at the same time copies its lower half into the buffer. The low byte is then read from the buffer. The external pin passes through a two-flop synchronizer and an edge detector in the system clock domain.

Top module: `evt_timer16`

## Requirements
- R1: After the synchronous reset, the counter, preload, buffer and control byte are zero, and `ovf_irq`, `freq_out` and `bus_rdata` are low.
- R2: The bus addresses are 0 for the low byte, 1 for the high byte, 2 for control and 3 reserved. A low-byte write only stores into the buffer. A high-byte write loads preload = {data, buffer}, and it also loads the counter with that value when the run bit is clear.
- R3: A read returns its data on `bus_rdata` one cycle after the strobe. A high-byte read returns counter[15:8] and copies counter[7:0] into the buffer. A low-byte read returns the buffer contents.
- R4: The control byte has these fields: bits [1:0] are the mode (00 idle, 01 event, 10 timer, 11 pulse width), bit 2 is run, bit 3 is polarity (0 = rising edge / high level, 1 = falling edge / low level) and bits [6:4] are the prescaler tap. Bit 7 reads 0. Address 3 reads 0 and writes to it are ignored.
- R5: In timer mode with tap s, the counter advances once every 2^(s+1) clocks. The first step comes 2^(s+1) clocks after the edge that set the run bit.
- R6: In event mode, the counter advances once for each synchronized rising edge (polarity 0) or falling edge (polarity 1) of `ext_in`.
- R7: Stepping from 0xFFFF reloads the counter from the preload register and drives `ovf_irq` high for exactly one cycle.
- R8: `freq_out` toggles on every overflow and on no other cycle.
- R9: In pulse-width mode, the counter advances on prescaler ticks only while `ext_in` is at the selected level. The run bit clears by itself once that level has been seen and then ends.
- R10: With the run bit clear, or with mode idle, the counter does not move, and it and the buffer keep their contents.
- R11: A high-byte write while the run bit is set changes only the preload register and does not touch the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ext_in | input | 1 | Asynchronous external event / pulse pin |
| ovf_irq | output | 1 | One-cycle overflow request |
| freq_out | output | 1 | Toggles on each overflow |

## Verification
The bench aims at the wrap from 0xFFFF to a preload value that was written while the counter was running. A design that reloaded from the old preload, or that let the high-byte write overwrite the live count, would return the wrong 16-bit value and the wrong overflow count. It also checks that a low-byte read returns the buffer and not the live count, and that a high-byte read refreshes that buffer. A design that read the live count directly would give a torn value. Finally, it checks exact prescaler step timing at several taps, and edge counting at both polarities. It also checks that pulse-width mode stops itself and freezes the captured width. A design that kept running there would let the width drift after the pulse ended.

// File: rtl/evt_timer16_pkg.sv
package evt_timer16_pkg;
  typedef enum logic [1:0] {
    MD_IDLE  = 2'b00,
    MD_EVENT = 2'b01,
    MD_TIMER = 2'b10,
    MD_PULSE = 2'b11
  } tmode_e;

  localparam logic [1:0] A_LO  = 2'd0;
  localparam logic [1:0] A_HI  = 2'd1;
  localparam logic [1:0] A_CTL = 2'd2;

  // control byte field positions
  localparam int CTL_RUN  = 2;
  localparam int CTL_POL  = 3;
  localparam int CTL_PSEL = 4;
endpackage

// File: rtl/tec_prescaler.sv
module tec_prescaler #(
  parameter int STAGES = 8,
  localparam int SEL_W = $clog2(STAGES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [STAGES-1:0] div_q;
  logic [STAGES-1:0] tap;

  always_ff @(posedge clk) begin
    if (rst || clr) div_q <= '0;
    else            div_q <= div_q + 1'b1;
  end

  // tap i fires once every 2^(i+1) clocks
  for (genvar i = 0; i < STAGES; i++) begin : g_tap
    assign tap[i] = &div_q[i:0];
  end

  assign tick = tap[sel];
endmodule

// File: rtl/tec_pin_sync.sv
module tec_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], pin};
  end

  assign level = sh_q[STAGES-1];
  assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall  = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/tec_core.sv
module tec_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         load_cnt,
  input  logic         pre_we,
  input  logic [W-1:0] pre_val,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] pre_q,
  output logic         ovf_q,
  output logic         freq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pre_q  <= '0;
      ovf_q  <= 1'b0;
      freq_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (pre_we) pre_q <= pre_val;
      if (load_cnt) begin
        cnt_q <= pre_val;
      end else if (inc) begin
        if (&cnt_q) begin
          cnt_q  <= pre_q;
          ovf_q  <= 1'b1;
          freq_q <= ~freq_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
  import evt_timer16_pkg::*;
#(
  parameter int BUS_W      = 8,
  parameter int PSC_STAGES = 8,
  parameter int SYNC_DEPTH = 2,
  localparam int CNT_W     = 2 * BUS_W,
  localparam int SEL_W     = $clog2(PSC_STAGES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             ext_in,
  output logic             ovf_irq,
  output logic             freq_out
);
  tmode_e             mode_q;
  logic               run_q, pol_q, seen_q;
  logic [SEL_W-1:0]   psel_q;
  logic [BUS_W-1:0]   lo_buf_q, rdata_q, ctl_rd;
  logic [CNT_W-1:0]   cnt_q, pre_q;
  logic               pin_lvl, pin_rise, pin_fall;
  logic               tick, inc, level_act, edge_hit, pw_end, counting;
  logic               wr_lo, wr_hi, wr_ctl, rd_hi;

  assign wr_lo  = bus_wr && (bus_addr == A_LO);
  assign wr_hi  = bus_wr && (bus_addr == A_HI);
  assign wr_ctl = bus_wr && (bus_addr == A_CTL);
  assign rd_hi  = bus_rd && (bus_addr == A_HI);

  tec_pin_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst), .pin(ext_in),
    .level(pin_lvl), .rise(pin_rise), .fall(pin_fall)
  );

  assign counting = run_q && (mode_q != MD_IDLE);

  tec_prescaler #(.STAGES(PSC_STAGES)) u_psc (
    .clk(clk), .rst(rst), .clr(!counting), .sel(psel_q), .tick(tick)
  );

  assign level_act = pol_q ? ~pin_lvl : pin_lvl;
  assign edge_hit  = pol_q ? pin_fall : pin_rise;
  assign pw_end    = run_q && (mode_q == MD_PULSE) && seen_q && !level_act;

  always_comb begin
    unique case (mode_q)
      MD_EVENT: inc = run_q && edge_hit;
      MD_TIMER: inc = run_q && tick;
      MD_PULSE: inc = run_q && tick && level_act;
      default:  inc = 1'b0;
    endcase
  end

  tec_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .inc(inc),
    .load_cnt(wr_hi && !run_q), .pre_we(wr_hi),
    .pre_val({bus_wdata, lo_buf_q}),
    .cnt_q(cnt_q), .pre_q(pre_q), .ovf_q(ovf_irq), .freq_q(freq_out)
  );

  // control register with pulse-width self-stop
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_IDLE;
      run_q  <= 1'b0;
      pol_q  <= 1'b0;
      psel_q <= '0;
      seen_q <= 1'b0;
    end else if (wr_ctl) begin
      mode_q <= tmode_e'(bus_wdata[1:0]);
      run_q  <= bus_wdata[CTL_RUN];
      pol_q  <= bus_wdata[CTL_POL];
      psel_q <= bus_wdata[CTL_PSEL +: SEL_W];
      seen_q <= 1'b0;
    end else if (pw_end) begin
      run_q  <= 1'b0;
      seen_q <= 1'b0;
    end else if (run_q && (mode_q == MD_PULSE) && level_act) begin
      seen_q <= 1'b1;
    end
  end

  // shared low-byte buffer: write data wins over read latch
  always_ff @(posedge clk) begin
    if (rst)        lo_buf_q <= '0;
    else if (wr_lo) lo_buf_q <= bus_wdata;
    else if (rd_hi) lo_buf_q <= cnt_q[BUS_W-1:0];
  end

  always_comb begin
    ctl_rd = '0;
    ctl_rd[1:0] = mode_q;
    ctl_rd[CTL_RUN] = run_q;
    ctl_rd[CTL_POL] = pol_q;
    ctl_rd[CTL_PSEL +: SEL_W] = psel_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      unique case (bus_addr)
        A_LO:    rdata_q <= lo_buf_q;
        A_HI:    rdata_q <= cnt_q[CNT_W-1:BUS_W];
        A_CTL:   rdata_q <= ctl_rd;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/evt_timer16_chk.sv
module evt_timer16_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         ovf_irq,
  input logic         freq_out,
  input logic [W-1:0] cnt,
  input logic [W-1:0] pre,
  input logic         run,
  input logic [1:0]   mode,
  input logic         seen,
  input logic         level_act,
  input logic         wr_ctl,
  input logic         wr_hi
);
  a_r7_irq_single: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |=> !ovf_irq);

  a_r7_reload: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |-> (cnt == $past(pre)));

  a_r8_freq_toggle: assert property (@(posedge clk) disable iff (rst)
    (freq_out != $past(freq_out)) == ovf_irq);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_hi) |=> $stable(cnt));

  a_r9_pw_stop: assert property (@(posedge clk) disable iff (rst)
    (run && (mode == 2'b11) && seen && !level_act && !wr_ctl) |=> !run);
endmodule

bind evt_timer16 evt_timer16_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ovf_irq(ovf_irq), .freq_out(freq_out),
  .cnt(cnt_q), .pre(pre_q), .run(run_q), .mode(mode_q),
  .seen(seen_q), .level_act(level_act), .wr_ctl(wr_ctl), .wr_hi(wr_hi)
);

// File: tb/sim_evt_timer16.sv
`timescale 1ns/1ps
module sim_evt_timer16;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ext_in = 1'b0;
  logic       ovf_irq, freq_out;

  int checks = 0, errors = 0;
  int irq_cnt = 0, irq_dbl = 0;
  logic irq_prev = 1'b0;
  logic exp_freq = 1'b0;

  always #2 clk = ~clk;

  evt_timer16 u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in),
    .ovf_irq(ovf_irq), .freq_out(freq_out)
  );

  always @(negedge clk) begin
    if (!rst && ovf_irq) irq_cnt++;
    if (!rst && ovf_irq && irq_prev) irq_dbl++;
    irq_prev = ovf_irq;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // tasks start and end at a negedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] h, l;
    rd(2'd1, h);
    rd(2'd0, l);
    v = {h, l};
  endtask

  task automatic load_stopped(input logic [15:0] v);
    wr(2'd0, v[7:0]);
    wr(2'd1, v[15:8]);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_in = 1'b1; repeat (3) @(negedge clk);
      ext_in = 1'b0; repeat (3) @(negedge clk);
    end
  endtask

  function automatic logic [15:0] model(input logic [15:0] st, input logic [15:0] pr,
                                        input int n, output int ov);
    logic [15:0] v = st;
    ov = 0;
    for (int i = 0; i < n; i++) begin
      if (v == 16'hFFFF) begin v = pr; ov++; end
      else v = v + 16'd1;
    end
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] v, ev;
    int ov, irq0, s, m;
    void'($urandom(32'd1357));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 irq/freq", {ovf_irq, freq_out}, 0);
    rd(2'd2, d); chk("R1 control", d, 0);
    rd16(v);     chk("R1 count", v, 0);

    // R2 / R3 buffered write and read
    load_stopped(16'h1234);
    rd(2'd1, d); chk("R2 high byte loaded", d, 8'h12);
    wr(2'd0, 8'hAB);
    rd(2'd0, d); chk("R3 low read returns buffer", d, 8'hAB);
    rd(2'd1, d); chk("R3 high read", d, 8'h12);
    rd(2'd0, d); chk("R3 low latched by high read", d, 8'h34);

    // R4 control layout, reserved address
    wr(2'd2, 8'h78);
    rd(2'd2, d); chk("R4 control readback", d, 8'h78);
    wr(2'd3, 8'hFF);
    rd(2'd2, d); chk("R4 addr3 write ignored", d, 8'h78);
    rd(2'd3, d); chk("R4 addr3 reads zero", d, 0);
    wr(2'd2, 8'h80);
    rd(2'd2, d); chk("R4 bit7 reads zero", d, 0);

    // R10 idle mode with run set, buffer kept
    wr(2'd0, 8'h5C);
    wr(2'd2, 8'h04);
    repeat (50) @(negedge clk);
    wr(2'd2, 8'h00);
    rd(2'd0, d); chk("R10 buffer kept", d, 8'h5C);
    rd16(v);     chk("R10 idle count held", v, 16'h1234);

    // R5 timer step timing at several taps
    begin
      int taps[3] = '{0, 2, 1};
      int lens[3] = '{10, 40, 7};
      for (int k = 0; k < 3; k++) begin
        load_stopped(16'h0000);
        wr(2'd2, 8'h06 | 8'(taps[k] << 4));
        repeat (lens[k] - 1) @(negedge clk);
        wr(2'd2, 8'h02 | 8'(taps[k] << 4));
        rd16(v);
        chk("R5 timer steps", v, lens[k] >> (taps[k] + 1));
      end
    end

    // R7 R8 R11 overflow with preload changed while running
    load_stopped(16'hFFFE);
    irq0 = irq_cnt;
    wr(2'd2, 8'h76);             // timer, run, tap 7: step every 256
    wr(2'd0, 8'hF0);
    wr(2'd1, 8'hFF);
    rd(2'd1, d); chk("R11 running count untouched", d, 8'hFF);
    repeat (1024 - 4) @(negedge clk);
    wr(2'd2, 8'h72);
    rd16(v);     chk("R7 reload from new preload", v, 16'hFFF2);
    chk("R7 one overflow request", irq_cnt - irq0, 1);
    exp_freq = ~exp_freq;
    chk("R8 freq toggled", freq_out, exp_freq);

    // R6 event count, both polarities
    load_stopped(16'h0000);
    wr(2'd2, 8'h05);
    pulses(7);
    wr(2'd2, 8'h01);
    rd16(v); chk("R6 rising edges", v, 7);
    load_stopped(16'h0000);
    wr(2'd2, 8'h0D);
    pulses(5);
    wr(2'd2, 8'h09);
    rd16(v); chk("R6 falling edges", v, 5);

    // R9 pulse width, self stop, frozen result
    load_stopped(16'h0000);
    wr(2'd2, 8'h07);
    repeat (5) @(negedge clk);
    rd(2'd2, d); chk("R9 armed while level inactive", d, 8'h07);
    ext_in = 1'b1;
    repeat (40) @(negedge clk);
    ext_in = 1'b0;
    repeat (10) @(negedge clk);
    rd(2'd2, d); chk("R9 run self-cleared", d, 8'h03);
    rd16(v);
    checks++;
    if (v < 19 || v > 21) begin
      errors++;
      $display("FAIL R9 width actual=%0d expected=19..21", v);
    end
    ext_in = 1'b1; repeat (20) @(negedge clk); ext_in = 1'b0;
    repeat (10) @(negedge clk);
    rd16(ev); chk("R9 width frozen", ev, v);

    // R5 R7 R8 R11 random timer runs against the model
    for (int it = 0; it < 24; it++) begin
      logic [15:0] st, pr;
      s  = $urandom_range(1, 3);
      m  = $urandom_range(4, 400);
      st = $urandom_range(0, 1) ? 16'hFFFF - 16'($urandom_range(0, 60)) : 16'($urandom);
      pr = 16'($urandom);
      load_stopped(st);
      irq0 = irq_cnt;
      wr(2'd2, 8'h06 | 8'(s << 4));
      wr(2'd0, pr[7:0]);
      wr(2'd1, pr[15:8]);
      repeat (m - 3) @(negedge clk);
      wr(2'd2, 8'h02 | 8'(s << 4));
      ev = model(st, pr, m >> (s + 1), ov);
      rd16(v);
      chk("R7 random count", v, ev);
      chk("R7 random overflows", irq_cnt - irq0, ov);
      if (ov % 2 == 1) exp_freq = ~exp_freq;
      chk("R8 random freq", freq_out, exp_freq);
    end

    chk("R7 irq never two cycles", irq_dbl, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule